// File: doc/BRIEF.md
# CPU Clock Stop and Park Controller

This block sits between a fast CPU-rate source clock and a set of differential CPU clock pairs. Each pair is generated as a registered true/complement signal at half the source rate. The block parks the pairs when either of two active-low inputs is asserted: a clock-stop request or a power-down request. Configuration inputs decide how each pair reacts. A per-pair free-run bit exempts that pair from the stop request. A per-pair enable bit can force that pair to high impedance. Two mode bits choose whether a parked pair holds its true line high or releases both lines.

Both request inputs are asynchronous, so each passes through a synchronizer first. Power-down is accepted only after the synchronized request has been seen low on consecutive samples. Power-down outranks the stop request. A pair changes state only at the clock edge that follows a high phase of its true line, so no shortened pulse can appear. Each pair reports a 2-bit drive-state code in place of an analog drive strength.

Top module: `cpu_clk_park_ctrl`

## Requirements
- R1: During and straight after reset every pair reports code 00 (running), with true low and complement high.
- R2: A pair in code 00 toggles its true line on every source clock edge, and its complement is always the inverse of the true line.
- R3: With the stop request low, only pairs whose free-run bit is 0 park. Pairs with free-run bit 1 stay in code 00 and keep toggling.
- R4: Under a stop request, a stoppable pair parks with code 01 (true high, complement low) when the stop-mode bit is 0. It parks with code 11 (both lines low, undriven) when the stop-mode bit is 1.
- R5: A power-down pulse shorter than the qualification window (two consecutive synchronized low samples) has no effect on any pair.
- R6: Under a qualified power-down, every enabled pair, including free-running ones, shows code 10 (true high, complement low) when the power-down-mode bit is 0. It shows code 11 when that bit is 1.
- R7: When power-down and the stop request are both asserted, the power-down code applies.
- R8: A pair's drive-state code changes only at a clock edge where its running true line had been high, so every running high or low phase lasts one full source period.
- R9: After the stop request is released, a parked pair is back in code 00 within 12 source clocks (6 CPU periods). When the stop-mode bit is 1, a pair leaving code 11 for running first spends one CPU period in code 01.
- R10: A pair whose enable bit is 0 goes to code 11 with both lines low, whatever the request inputs are.
- R11: The request inputs pass through two synchronizer flops. A stop request cannot change any pair's code within two source edges of its assertion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | CPU-rate source clock |
| rst_ni | input | 1 | Active-low reset |
| stop_ni | input | 1 | Asynchronous active-low clock-stop request |
| pdn_ni | input | 1 | Asynchronous active-low power-down request |
| stop_float_i | input | 1 | Stop-mode bit: 0 parks true high, 1 parks undriven |
| pdn_float_i | input | 1 | Power-down-mode bit: 0 parks true high, 1 parks undriven |
| freerun_i | input | NUM_PAIRS | Per-pair free-run select (1 = ignores the stop request) |
| oe_i | input | NUM_PAIRS | Per-pair output enable (0 = high impedance) |
| clk_t_o | output | NUM_PAIRS | True line of each pair |
| clk_c_o | output | NUM_PAIRS | Complement line of each pair |
| drive_o | output | 2*NUM_PAIRS | Per-pair drive-state code, pair i in bits [2i+1:2i] |

## Verification
The block is driven with a mix of stoppable and free-running pairs under stop requests in both stop modes. This shows whether the free-run bit alone decides which pairs park, and whether the mode bit alone decides the parked code. Power-down is applied once as a one-cycle pulse and once held long, so a missing qualification window can be told apart from a missing park. It is also held on top of an active stop request, in both power-down modes, which shows the priority between the two. Releases of the stop request are timed to expose the resume latency and the intermediate high step, and an enable bit is dropped mid-run. A cycle-accurate model compares every pair's lines and code on each clock.

// File: rtl/cpu_park_pkg.sv
package cpu_park_pkg;
   typedef enum logic [1:0] {
      DRV_RUN  = 2'b00,
      DRV_HI6X = 2'b01,
      DRV_HI2X = 2'b10,
      DRV_HIZ  = 2'b11
   } drv_e;
endpackage

// File: rtl/cpu_park_sync.sv
module cpu_park_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);
   generate
      if (STAGES < 2) begin : g_bad
         initial $error("cpu_park_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
      else         chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/cpu_park_lane.sv
module cpu_park_lane
   import cpu_park_pkg::*;
(
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       phase_i,
   input  logic       stop_act_i,
   input  logic       pdn_act_i,
   input  logic       stop_float_i,
   input  logic       pdn_float_i,
   input  logic       freerun_i,
   input  logic       oe_i,
   output logic       t_o,
   output logic       c_o,
   output logic [1:0] drv_o
);
   drv_e state_q, want, next_state;

   // target code, highest priority first
   always_comb begin
      if (!oe_i)                        want = DRV_HIZ;
      else if (pdn_act_i)               want = pdn_float_i ? DRV_HIZ : DRV_HI2X;
      else if (stop_act_i && !freerun_i) want = stop_float_i ? DRV_HIZ : DRV_HI6X;
      else                              want = DRV_RUN;
   end

   // commit only after a high phase; leaving Hi-Z drives high first
   always_comb begin
      next_state = state_q;
      if (phase_i) begin
         if (state_q == DRV_HIZ && want == DRV_RUN && stop_float_i)
            next_state = DRV_HI6X;
         else
            next_state = want;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) state_q <= DRV_RUN;
      else         state_q <= next_state;
   end

   always_comb begin
      unique case (state_q)
         DRV_RUN:  begin t_o = phase_i; c_o = ~phase_i; end
         DRV_HI6X,
         DRV_HI2X: begin t_o = 1'b1;    c_o = 1'b0;     end
         default:  begin t_o = 1'b0;    c_o = 1'b0;     end
      endcase
   end

   assign drv_o = state_q;
endmodule

// File: rtl/cpu_clk_park_ctrl.sv
module cpu_clk_park_ctrl #(
   parameter int NUM_PAIRS   = 3,
   parameter int SYNC_STAGES = 2,
   parameter int PDN_SAMPLES = 2
) (
   input  logic                   clk_i,
   input  logic                   rst_ni,
   input  logic                   stop_ni,
   input  logic                   pdn_ni,
   input  logic                   stop_float_i,
   input  logic                   pdn_float_i,
   input  logic [NUM_PAIRS-1:0]   freerun_i,
   input  logic [NUM_PAIRS-1:0]   oe_i,
   output logic [NUM_PAIRS-1:0]   clk_t_o,
   output logic [NUM_PAIRS-1:0]   clk_c_o,
   output logic [2*NUM_PAIRS-1:0] drive_o
);
   localparam int HIST_W = (PDN_SAMPLES > 1) ? PDN_SAMPLES - 1 : 1;

   generate
      if (NUM_PAIRS < 1) begin : g_bad_pairs
         initial $error("cpu_clk_park_ctrl: NUM_PAIRS must be at least 1");
      end
      if (PDN_SAMPLES < 1) begin : g_bad_samples
         initial $error("cpu_clk_park_ctrl: PDN_SAMPLES must be at least 1");
      end
   endgenerate

   logic stop_s, pdn_s, stop_act, pdn_act, ph_q;

   cpu_park_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_stop_sync (
      .clk_i(clk_i), .rst_ni(rst_ni), .d_i(stop_ni), .q_o(stop_s));
   cpu_park_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_pdn_sync (
      .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pdn_ni), .q_o(pdn_s));

   assign stop_act = ~stop_s;

   generate
      if (PDN_SAMPLES > 1) begin : g_pdn_win
         logic [HIST_W-1:0] hist_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) hist_q <= '1;
            else begin
               hist_q[0] <= pdn_s;
               for (int k = 1; k < HIST_W; k++) hist_q[k] <= hist_q[k-1];
            end
         end
         assign pdn_act = ~pdn_s & ~(|hist_q);
      end else begin : g_pdn_direct
         assign pdn_act = ~pdn_s;
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ph_q <= 1'b0;
      else         ph_q <= ~ph_q;
   end

   generate
      for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_pair
         cpu_park_lane i_lane (
            .clk_i       (clk_i),
            .rst_ni      (rst_ni),
            .phase_i     (ph_q),
            .stop_act_i  (stop_act),
            .pdn_act_i   (pdn_act),
            .stop_float_i(stop_float_i),
            .pdn_float_i (pdn_float_i),
            .freerun_i   (freerun_i[i]),
            .oe_i        (oe_i[i]),
            .t_o         (clk_t_o[i]),
            .c_o         (clk_c_o[i]),
            .drv_o       (drive_o[2*i+1:2*i])
         );
      end
   endgenerate
endmodule

// File: rtl/cpu_park_checker.sv
module cpu_park_checker #(
   parameter int NUM_PAIRS = 3
) (
   input logic                   clk_i,
   input logic                   rst_ni,
   input logic [NUM_PAIRS-1:0]   oe_i,
   input logic [NUM_PAIRS-1:0]   clk_t_o,
   input logic [NUM_PAIRS-1:0]   clk_c_o,
   input logic [2*NUM_PAIRS-1:0] drive_o,
   input logic                   ph_q,
   input logic                   pdn_act
);
   generate
      for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_chk
         AST_RUN_COMPLEMENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (drive_o[2*i+1:2*i] == 2'b00) |-> (clk_t_o[i] != clk_c_o[i])); // R2
         AST_PARK_TRUE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (drive_o[2*i+1:2*i] == 2'b01 || drive_o[2*i+1:2*i] == 2'b10)
            |-> (clk_t_o[i] && !clk_c_o[i])); // R4
         AST_HIZ_BOTH_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (drive_o[2*i+1:2*i] == 2'b11) |-> (!clk_t_o[i] && !clk_c_o[i])); // R10
         AST_CHANGE_AFTER_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (drive_o[2*i+1:2*i] != $past(drive_o[2*i+1:2*i])) |-> $past(ph_q)); // R8
         AST_PDN_PARKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
            ($past(pdn_act) && $past(pdn_act, 2)) |-> drive_o[2*i+1]); // R6
         AST_DISABLED_HIZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!$past(oe_i[i]) && !$past(oe_i[i], 2)) |-> (drive_o[2*i+1:2*i] == 2'b11)); // R10
      end
   endgenerate
endmodule

bind cpu_clk_park_ctrl cpu_park_checker #(.NUM_PAIRS(NUM_PAIRS)) i_chk (
   .clk_i  (clk_i),
   .rst_ni (rst_ni),
   .oe_i   (oe_i),
   .clk_t_o(clk_t_o),
   .clk_c_o(clk_c_o),
   .drive_o(drive_o),
   .ph_q   (ph_q),
   .pdn_act(pdn_act)
);

// File: tb/test_cpu_clk_park_ctrl.sv
module test_cpu_clk_park_ctrl;
   localparam int NP = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          stop_n = 1'b1, pdn_n = 1'b1;
   logic          stop_float = 1'b0, pdn_float = 1'b0;
   logic [NP-1:0] freerun = '0, oe = '1;
   logic [NP-1:0] t_o, c_o;
   logic [2*NP-1:0] drv_o;

   int n_checks = 0, n_fail = 0;
   bit done = 0;

   always #5 clk = ~clk;

   cpu_clk_park_ctrl #(.NUM_PAIRS(NP)) i_cpu_clk_park_ctrl (
      .clk_i(clk), .rst_ni(rst_n), .stop_ni(stop_n), .pdn_ni(pdn_n),
      .stop_float_i(stop_float), .pdn_float_i(pdn_float),
      .freerun_i(freerun), .oe_i(oe),
      .clk_t_o(t_o), .clk_c_o(c_o), .drive_o(drv_o));

   task automatic check(string tag, int act, int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int code_of(int i);
      return int'(drv_o[2*i +: 2]);
   endfunction

   // behavioural reference model
   int m_st[NP];
   bit m_ph, m_s1, m_s2, m_p1, m_p2, m_p3;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         foreach (m_st[i]) m_st[i] = 0;
         m_ph = 0; m_s1 = 1; m_s2 = 1; m_p1 = 1; m_p2 = 1; m_p3 = 1;
      end else begin
         bit stp, pd;
         stp = !m_s2;
         pd  = !m_p2 && !m_p3;
         for (int i = 0; i < NP; i++) begin
            int w;
            if (!oe[i])                 w = 3;
            else if (pd)                w = pdn_float ? 3 : 2;
            else if (stp && !freerun[i]) w = stop_float ? 3 : 1;
            else                        w = 0;
            if (m_ph) m_st[i] = (m_st[i] == 3 && w == 0 && stop_float) ? 1 : w;
         end
         m_p3 = m_p2; m_p2 = m_p1; m_p1 = pdn_n;
         m_s2 = m_s1; m_s1 = stop_n;
         m_ph = !m_ph;
      end
   end

   // per-clock comparison plus glitch monitor for R8
   int prev_code0 = 0, prev_t0 = 0, runt_cnt = 0;
   always @(negedge clk) begin
      if (rst_n && !done) begin
         for (int i = 0; i < NP; i++) begin
            int et, ec;
            string tg;
            et = (m_st[i] == 0) ? int'(m_ph) : (m_st[i] == 1 || m_st[i] == 2) ? 1 : 0;
            ec = (m_st[i] == 0) ? int'(!m_ph) : 0;
            case (m_st[i])
               0: tg = "R2 running";
               1: tg = "R4 stop park high";
               2: tg = "R6 power-down park";
               default: tg = "R10 hi-z";
            endcase
            check(tg, {code_of(i), int'(t_o[i]), int'(c_o[i])}, {m_st[i], et, ec});
         end
         if (code_of(0) != prev_code0 && prev_code0 == 0 && prev_t0 != 1) runt_cnt++;
         prev_code0 = code_of(0);
         prev_t0 = int'(t_o[0]);
      end
   end

   task automatic wait_n(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic resume_latency(bit flt);
      int cnt = 0;
      bit saw_hi = 0;
      stop_n = 1'b1;
      while (cnt < 20) begin
         @(negedge clk);
         cnt++;
         if (code_of(0) == 1) saw_hi = 1;
         if (code_of(0) == 0) break;
      end
      check("R9 resume within 12 clocks", int'(cnt >= 3 && cnt <= 12), 1);
      if (flt) check("R9 high step before resume", int'(saw_hi), 1);
   endtask

   initial begin
      wait_n(1);
      check("R1 reset code", int'(drv_o), 0);
      check("R1 reset lines", {int'(t_o), int'(c_o)}, {0, 7});
      wait_n(2);
      rst_n = 1'b1;
      wait_n(20);

      // stop, mode 0, pair1 free-running
      freerun = 3'b010; stop_float = 1'b0;
      stop_n = 1'b0;
      wait_n(2);
      check("R11 no park within two edges", code_of(0), 0);
      wait_n(18);
      check("R4 stop park code 01", code_of(0), 1);
      check("R3 stoppable pair2 parks", code_of(2), 1);
      check("R3 free-running pair1 runs", code_of(1), 0);
      resume_latency(1'b0);
      wait_n(10);

      // stop, mode 1
      stop_float = 1'b1;
      stop_n = 1'b0;
      wait_n(20);
      check("R4 stop park code 11", code_of(0), 3);
      check("R4 hi-z lines low", int'(t_o[0] | c_o[0]), 0);
      resume_latency(1'b1);
      wait_n(10);

      // short power-down pulse is ignored
      pdn_n = 1'b0;
      wait_n(1);
      pdn_n = 1'b1;
      for (int k = 0; k < 10; k++) begin
         wait_n(1);
         check("R5 short pulse ignored", int'(drv_o), 0);
      end

      // power-down over stop, both modes
      stop_float = 1'b0; pdn_float = 1'b0;
      stop_n = 1'b0; pdn_n = 1'b0;
      wait_n(20);
      for (int i = 0; i < NP; i++) check("R7 power-down wins code 10", code_of(i), 2);
      pdn_float = 1'b1;
      wait_n(10);
      for (int i = 0; i < NP; i++) check("R6 power-down hi-z code 11", code_of(i), 3);
      pdn_n = 1'b1; stop_n = 1'b1; pdn_float = 1'b0;
      wait_n(20);
      check("R6 released back to run", int'(drv_o), 0);

      // output enable
      oe = 3'b011;
      wait_n(10);
      check("R10 disabled pair hi-z", code_of(2), 3);
      check("R10 other pairs unaffected", code_of(0), 0);
      oe = 3'b111;
      wait_n(20);
      check("R8 no shortened phase", runt_cnt, 0);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end
endmodule